// File: doc/BRIEF.md
# Oscillation Stabilization Wait Controller

This block decides when the CPU clock may run again after the chip leaves its low-power STOP state. While the CPU is running, a STOP request puts the block into STOP and gates the CPU clock off. If the interrupt logic already signals a pending, unmasked wake-up when the request arrives, the block goes to HALT instead. From STOP, a wake-up moves the block into WAIT. From WAIT or HALT, the block counts oscillator-running cycles until the selected stabilization time has passed, and then returns to RUN.

A 3-bit select register chooses one of five stabilization durations. A 5-bit status field shows the progress of the wait. Its bits rise one at a time, lowest threshold first, and each bit stays set. Both registers are reached through a small write port and a one-cycle-latency read port. The parameter `TIME_SCALE_LOG2` divides every duration by a power of two, so that short configurations can be built.

Top module: `osc_wait_ctrl`

## Requirements
- R1: Synchronous reset gives mode RUN, `cpu_clk_en`=1 and status 0, and the select register reads 4 (the longest duration). While reset is held, the counter does not advance.
- R2: In RUN, a `stop_req` with `wake_req` low gives mode STOP on the next cycle. It clears all status bits and restarts the counter from zero.
- R3: The block stays in STOP until `wake_req` is seen. On that edge it moves to WAIT.
- R4: In WAIT and HALT, the counter advances only on cycles where `osc_run`=1. The block returns to RUN on the edge where the count reaches the selected threshold.
- R5: Select codes 0, 1, 2, 3 and 4 choose thresholds of 2^11, 2^13, 2^14, 2^15 and 2^16 counts, each divided by 2^`TIME_SCALE_LOG2`. Codes 5, 6 and 7 choose the longest threshold.
- R6: Status bit i (bit 0 = shortest threshold) sets on the edge where the count reaches threshold i and then stays set. The field is always a thermometer code, and no bit above the selected duration is ever set.
- R7: In RUN, a `stop_req` with `wake_req` high gives mode HALT on the next cycle and clears the status. The block then returns to RUN after the selected wait.
- R8: A write to the select register during a wait does not change the wait in progress. The new value governs the next wait.
- R9: Reads return data on the cycle after `rd_addr` is applied. Address 0 gives the select code in bits [2:0]. Address 1 gives the status in bits [4:0]. All other bits read 0.
- R10: `cpu_clk_en` is 1 exactly when the mode is RUN. The mode encoding is RUN=0, HALT=1, STOP=2, WAIT=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to enter STOP |
| wake_req | input | 1 | Pending unmasked interrupt (wake-up) |
| osc_run | input | 1 | Oscillator is running and its cycles may be counted |
| wr_en | input | 1 | Write strobe for the select register |
| wr_data | input | 3 | Select code to write |
| rd_addr | input | 1 | Read address: 0 select, 1 status |
| rd_data | output | 8 | Registered read data |
| cpu_clk_en | output | 1 | CPU clock enable |
| mode | output | 2 | Current mode: RUN=0, HALT=1, STOP=2, WAIT=3 |

## Verification
The bench sweeps all eight select codes. For each code it counts the exact number of oscillator cycles before RUN returns, so a wrong threshold table, a counter that is off by one, or reserved codes that are not clamped all show up as a wrong cycle count. It stops the oscillator in the middle of the wait and checks that neither the mode nor the status moves. A design that counted raw clocks would return to RUN early, and a design that set status bits out of order would show a non-thermometer read. It also tests the pending-interrupt path into HALT and a select write made during a wait. The first would wrongly land in STOP, and the second would shorten or stretch the wait in progress.

// File: rtl/osw_pkg.sv
package osw_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_WAIT = 2'd3
  } osw_mode_e;

  localparam int unsigned NUM_STEPS = 5;

  // log2 of the unscaled threshold for step idx: 11, 13, 14, 15, 16
  function automatic int unsigned step_exp(input int unsigned idx);
    return (idx == 0) ? 11 : 12 + idx;
  endfunction
endpackage

// File: rtl/osw_sel_reg.sv
module osw_sel_reg #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             capture,
  output logic [SEL_W-1:0] sel_q,
  output logic [SEL_W-1:0] act_idx
);
  import osw_pkg::*;
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_STEPS - 1);

  logic [SEL_W-1:0] dec_idx;

  // codes past the last step clamp to the longest duration
  always_comb dec_idx = (sel_q > LAST_IDX) ? LAST_IDX : sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= LAST_IDX;
    else if (wr_en) sel_q <= wr_data;
  end

  // the active duration is frozen when a low-power state is entered
  always_ff @(posedge clk) begin
    if (rst) act_idx <= LAST_IDX;
    else if (capture) act_idx <= dec_idx;
  end
endmodule

// File: rtl/osw_stab_counter.sv
module osw_stab_counter #(
  parameter int unsigned SCALE = 0,
  parameter int unsigned IDX_W = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clear,
  input  logic                           run,
  input  logic [IDX_W-1:0]               act_idx,
  output logic [osw_pkg::NUM_STEPS-1:0]  status,
  output logic                           done
);
  import osw_pkg::*;
  localparam int unsigned CNT_W   = 17 - SCALE;
  localparam int unsigned TAB_LEN = 2 ** IDX_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] thr_tab [TAB_LEN];

  always_comb cnt_n = cnt_q + 1'b1;

  for (genvar k = 0; k < TAB_LEN; k++) begin : g_tab
    localparam int unsigned IDX = (k < NUM_STEPS) ? k : NUM_STEPS - 1;
    localparam int unsigned EXP = step_exp(IDX) - SCALE;
    assign thr_tab[k] = CNT_W'(1) << EXP;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run) cnt_q <= cnt_n;
  end

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst || clear) status[i] <= 1'b0;
      else if (run && (act_idx >= IDX_W'(i)) && (cnt_n == thr_tab[i]))
        status[i] <= 1'b1;
    end
  end

  always_comb done = run && (cnt_n == thr_tab[act_idx]);
endmodule

// File: rtl/osw_mode_fsm.sv
module osw_mode_fsm (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req,
  input  logic               wake_req,
  input  logic               osc_run,
  input  logic               done,
  output osw_pkg::osw_mode_e mode_q,
  output logic               clk_en_q,
  output logic               enter,
  output logic               run
);
  import osw_pkg::*;
  osw_mode_e nxt;

  always_comb begin
    nxt   = mode_q;
    enter = 1'b0;
    unique case (mode_q)
      MODE_RUN: if (stop_req) begin
        enter = 1'b1;
        nxt   = wake_req ? MODE_HALT : MODE_STOP;
      end
      MODE_STOP: if (wake_req) nxt = MODE_WAIT;
      MODE_WAIT, MODE_HALT: if (done) nxt = MODE_RUN;
      default: nxt = MODE_RUN;
    endcase
  end

  always_comb run = osc_run && ((mode_q == MODE_WAIT) || (mode_q == MODE_HALT));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RUN;
      clk_en_q <= 1'b1;
    end else begin
      mode_q   <= nxt;
      clk_en_q <= (nxt == MODE_RUN);
    end
  end
endmodule

// File: rtl/osc_wait_ctrl.sv
module osc_wait_ctrl #(
  parameter int unsigned TIME_SCALE_LOG2 = 0,
  parameter int unsigned SEL_W           = 3,
  parameter int unsigned DATA_W          = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              wake_req,
  input  logic              osc_run,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cpu_clk_en,
  output logic [1:0]        mode
);
  import osw_pkg::*;

  osw_mode_e              mode_q;
  logic                   enter;
  logic                   run;
  logic                   done;
  logic [SEL_W-1:0]       sel_q;
  logic [SEL_W-1:0]       act_idx;
  logic [NUM_STEPS-1:0]   status;

  osw_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .capture(enter), .sel_q(sel_q), .act_idx(act_idx)
  );

  osw_stab_counter #(.SCALE(TIME_SCALE_LOG2), .IDX_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(enter), .run(run),
    .act_idx(act_idx), .status(status), .done(done)
  );

  osw_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake_req(wake_req),
    .osc_run(osc_run), .done(done), .mode_q(mode_q),
    .clk_en_q(cpu_clk_en), .enter(enter), .run(run)
  );

  assign mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr) rd_data <= DATA_W'(status);
    else rd_data <= DATA_W'(sel_q);
  end
endmodule

// File: rtl/osw_checker.sv
module osw_checker (
  input logic       clk,
  input logic       rst,
  input logic       stop_req,
  input logic       wake_req,
  input logic       osc_run,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic [4:0] status
);
  localparam logic [1:0] M_RUN = 2'd0, M_HALT = 2'd1, M_STOP = 2'd2, M_WAIT = 2'd3;

  AST_CLKEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en == (mode == M_RUN)); // R10
  AST_ENTER_STOP: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RUN && stop_req && !wake_req) |=> (mode == M_STOP && status == 5'd0)); // R2
  AST_ENTER_HALT: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RUN && stop_req && wake_req) |=> (mode == M_HALT && status == 5'd0)); // R7
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == M_STOP && !wake_req) |=> mode == M_STOP); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (mode == M_STOP && wake_req) |=> mode == M_WAIT); // R3
  AST_THERMO: assert property (@(posedge clk) disable iff (rst)
    ((5'(status + 5'd1)) & status) == 5'd0); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(mode == M_RUN && stop_req) |=> (status & $past(status)) == $past(status)); // R6
  AST_NO_OSC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mode == M_WAIT && !osc_run) |=> (mode == M_WAIT && $stable(status))); // R4
endmodule

bind osc_wait_ctrl osw_checker u_osw_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .wake_req(wake_req),
  .osc_run(osc_run), .mode(mode), .cpu_clk_en(cpu_clk_en), .status(status)
);

// File: tb/tb_osc_wait_ctrl.sv
module tb_osc_wait_ctrl;
  localparam int unsigned SCALE = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_req = 1'b0, wake_req = 1'b0, osc_run = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = 3'd0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       cpu_clk_en;
  logic [1:0] mode;

  int checks = 0;
  int failures = 0;

  osc_wait_ctrl #(.TIME_SCALE_LOG2(SCALE)) dut (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake_req(wake_req),
    .osc_run(osc_run), .wr_en(wr_en), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cpu_clk_en(cpu_clk_en), .mode(mode)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int idx_of(input int code);
    return (code > 4) ? 4 : code;
  endfunction
  function automatic int thr_of(input int idx);
    return 1 << (((idx == 0) ? 11 : 12 + idx) - SCALE);
  endfunction

  // called at a negedge; returns at a negedge
  task automatic do_read(input logic a, output int v);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_write(input int code);
    wr_en = 1'b1; wr_data = 3'(code);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts osc cycles until RUN; optional pause after the first threshold
  task automatic count_to_run(input int pause_at, output int n);
    int v;
    n = 0;
    osc_run = 1'b1;
    while (mode != 2'd0 && n < 2000) begin
      @(negedge clk);
      n++;
      if (n == pause_at && mode != 2'd0) begin
        osc_run = 1'b0;
        do_read(1'b1, v);
        chk("R6 status after first threshold", v, 1);
        @(negedge clk);
        chk("R4 held without oscillator", mode, 3);
        do_read(1'b1, v);
        chk("R4 status frozen without oscillator", v, 1);
        osc_run = 1'b1;
      end
    end
    osc_run = 1'b0;
  endtask

  task automatic stop_cycle(input int code, input int exp_code, input bit pause, input bit mid_write);
    int v, n, idx;
    idx = idx_of(exp_code);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R2 mode STOP", mode, 2);
    chk("R10 clock gated in STOP", cpu_clk_en, 0);
    do_read(1'b1, v);
    chk("R2 status cleared", v, 0);
    repeat (5) @(negedge clk);
    chk("R3 STOP held", mode, 2);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk("R3 released to WAIT", mode, 3);
    chk("R10 clock gated in WAIT", cpu_clk_en, 0);
    if (mid_write) do_write(code);
    repeat (4) @(negedge clk);
    chk("R4 no count before oscillator", mode, 3);
    count_to_run((pause && idx > 0) ? thr_of(0) : -1, n);
    chk($sformatf("R5 wait length code %0d", exp_code), n, thr_of(idx));
    chk("R10 clock on in RUN", cpu_clk_en, 1);
    do_read(1'b1, v);
    chk("R6 final thermometer", v, (1 << (idx + 1)) - 1);
  endtask

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    chk("R1 reset holds RUN", mode, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode RUN", mode, 0);
    chk("R1 clock enabled", cpu_clk_en, 1);
    do_read(1'b0, v);
    chk("R1 select resets to 4", v, 4);
    do_read(1'b1, v);
    chk("R1 status zero", v, 0);

    // sweep all select codes through STOP/WAIT
    for (int c = 0; c < 8; c++) begin
      do_write(c);
      do_read(1'b0, v);
      chk("R9 select readback", v, c);
      stop_cycle(c, c, 1'b1, 1'b0);
    end

    // pending interrupt: STOP request drops to HALT
    for (int c = 0; c < 5; c++) begin
      do_write(c);
      stop_req = 1'b1; wake_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0; wake_req = 1'b0;
      chk("R7 mode HALT", mode, 1);
      chk("R10 clock gated in HALT", cpu_clk_en, 0);
      count_to_run(-1, n);
      chk("R7 HALT wait length", n, thr_of(c));
      do_read(1'b1, v);
      chk("R7 HALT status", v, (1 << (c + 1)) - 1);
    end

    // write during wait affects only the next wait
    do_write(2);
    stop_cycle(0, 2, 1'b0, 1'b1);
    do_read(1'b0, v);
    chk("R8 new select stored", v, 0);
    stop_cycle(0, 0, 1'b0, 1'b0);

    // reset in the middle of a wait
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    osc_run = 1'b1; repeat (3) @(negedge clk);
    rst = 1'b1; @(negedge clk);
    chk("R1 reset returns RUN", mode, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0; osc_run = 1'b0;
    @(negedge clk);
    do_read(1'b1, v);
    chk("R1 status zero after reset", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule